// File: doc/BRIEF.md
# Board-Control Register Bank with Interrupt Aggregator

This peripheral sits on a simple synchronous register bus. It holds ten general 32-bit storage registers for board functions: two LED data words, an LED control word, a switch word, three miscellaneous control words, a miscellaneous status word and two card-slot words. The hardware that uses these values lives outside the block. Every one of these registers keeps whatever the host last wrote.

The block also gathers sixteen level-sensitive external interrupt lines into one interrupt line toward the host. It samples the lines once per clock and compares each sample with the levels it recorded on the previous clock.

When an enabled line has changed, the block does two things:
- It overwrites the event register with a one-hot code that names that line.
- It drives the host interrupt line to that line's new level.

Lines whose enable bit is clear are tracked silently. The enable register and the event register keep only a fixed subset of bits. Because of that subset, lines 8 and 12 can never be enabled.

Top module: `board_ctrl_hub`

## Requirements
- R1: The ten storage registers at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each store all 32 written bits and return them unchanged.
- R2: A write takes effect at the clock edge on which `bus_we` is high. `bus_rdata` shows, one edge after `bus_addr` is presented, the value the addressed register held before that edge.
- R3: The enable register (offset 0xC0) and the event register (offset 0xD0) keep only the bits set in 0x000FEEFF. Every other bit reads back as zero.
- R4: When an input line differs from its recorded level and its enable bit (bit n of 0xC0 for line n) is set, the event register becomes a value with only bit n set, at that edge.
- R5: In the same case, `irq_out` takes the new level of line n at that edge.
- R6: A line that changes while its enable bit is clear updates the recorded level but leaves the event register and `irq_out` unchanged. Enabling the line afterwards raises no event for that earlier change.
- R7: When several enabled lines change at the same edge, the lowest-numbered one sets the code and drives `irq_out`.
- R8: Reads of any offset not listed in R1 or R3 return zero. Writes to such offsets change no register.
- R9: A synchronous active-high `rst` clears all registers, the recorded levels, `irq_out` and `bus_rdata` to zero.
- R10: Lines 8 and 12 never produce an event, because their enable bits cannot be stored (R3).
- R11: If an interrupt event and a bus write to the event register fall on the same edge, the interrupt event's one-hot code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External level-sensitive interrupt lines |
| irq_out | output | 1 | Aggregated interrupt line to the host |

## Verification
A write becomes visible at the edge on which it is strobed. Read data belongs to the address presented before the previous edge, so it appears one edge later. An interrupt change on `irq_in` shows up in the event register and on `irq_out` at the first edge that samples it. Any readback of the event register adds one more edge of read latency.

The bench drives every input at the falling edge. A behavioural model advances at each rising edge, computing read data from the state before that edge's writes. The bench compares `bus_rdata` and `irq_out` against the model at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int N_IRQ      = 16;
    localparam int N_PLAIN    = 10;

    localparam logic [DATA_W-1:0] IRQ_KEEP_MASK = 32'h000F_EEFF;
    localparam logic [ADDR_W-1:0] OFF_ENABLE    = 8'hC0;
    localparam logic [ADDR_W-1:0] OFF_EVENT     = 8'hD0;

    // Offset of each plain storage register, by index.
    function automatic logic [ADDR_W-1:0] plain_off(input int idx);
        case (idx)
            0: return 8'h10;
            1: return 8'h14;
            2: return 8'h40;
            3: return 8'h60;
            4: return 8'h80;
            5: return 8'h84;
            6: return 8'h88;
            7: return 8'h90;
            8: return 8'hE0;
            default: return 8'hE4;
        endcase
    endfunction

    typedef struct packed {
        logic             hit;
        logic [N_IRQ-1:0] code;
        logic             lvl;
    } irq_evt_t;

endpackage

// File: rtl/bc_reg_bank.sv
module bc_reg_bank
    import board_ctrl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = N_PLAIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic          rd_hit,
    output logic [DW-1:0] rd_val
);

    logic [NR-1:0]         sel;
    logic [NR-1:0][DW-1:0] store_q;

    for (genvar g = 0; g < NR; g++) begin : g_slot
        assign sel[g] = (addr == AW'(plain_off(g)));

        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (we && sel[g]) begin
                store_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NR; k++) begin
            if (sel[k]) rd_val = rd_val | store_q[k];
        end
    end

    assign rd_hit = |sel;

endmodule

// File: rtl/bc_irq_unit.sv
module bc_irq_unit
    import board_ctrl_pkg::*;
#(
    parameter int NI = N_IRQ
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NI-1:0] irq_in,
    input  logic [NI-1:0] en_bits,
    output irq_evt_t      evt
);

    logic [NI-1:0] prev_q;
    logic [NI-1:0] changed;
    logic [NI-1:0] armed;
    logic [NI-1:0] winner;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    assign changed = irq_in ^ prev_q;
    assign armed   = changed & en_bits;
    assign winner  = armed & (~armed + NI'(1));

    assign evt.hit  = |armed;
    assign evt.code = winner;
    assign evt.lvl  = |(winner & irq_in);

    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        evt.hit |-> ($onehot(evt.code) && ((armed & (evt.code - NI'(1))) == '0)));

endmodule

// File: rtl/board_ctrl_hub.sv
module board_ctrl_hub
    import board_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_IRQ-1:0]    irq_in,
    output logic                irq_out
);

    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ev_q;
    logic              bank_hit;
    logic [DATA_W-1:0] bank_val;
    logic [DATA_W-1:0] rd_mux;
    irq_evt_t          evt;
    logic              wr_en_reg;
    logic              wr_ev_reg;

    bc_reg_bank #(.AW(ADDR_W), .DW(DATA_W), .NR(N_PLAIN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rd_hit (bank_hit),
        .rd_val (bank_val)
    );

    bc_irq_unit #(.NI(N_IRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .en_bits (en_q[N_IRQ-1:0]),
        .evt     (evt)
    );

    assign wr_en_reg = bus_we && (bus_addr == OFF_ENABLE);
    assign wr_ev_reg = bus_we && (bus_addr == OFF_EVENT);

    always_comb begin
        if (bank_hit)                     rd_mux = bank_val;
        else if (bus_addr == OFF_ENABLE)  rd_mux = en_q;
        else if (bus_addr == OFF_EVENT)   rd_mux = ev_q;
        else                              rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            ev_q      <= '0;
            irq_out   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_mux;
            if (wr_en_reg) en_q <= bus_wdata & IRQ_KEEP_MASK;
            if (evt.hit) begin
                ev_q    <= DATA_W'(evt.code);
                irq_out <= evt.lvl;
            end else if (wr_ev_reg) begin
                ev_q <= bus_wdata & IRQ_KEEP_MASK;
            end
        end
    end

    a_r3_event_masked: assert property (@(posedge clk) disable iff (rst)
        (ev_q & ~IRQ_KEEP_MASK) == '0);

    a_r4_event_onehot: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> $onehot(ev_q));

    a_r5_out_level: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> (irq_out == |($past(irq_in) & ev_q[N_IRQ-1:0])));

    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        !evt.hit |=> $stable(irq_out));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (irq_out == 1'b0 && bus_rdata == '0));

endmodule

// File: tb/board_ctrl_hub_test.sv
module board_ctrl_hub_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    board_ctrl_hub uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // Behavioural model
    logic [31:0] m_mem [int];
    logic [31:0] m_en, m_st, m_rd, rd_next;
    logic [15:0] m_prev, hit;
    logic        m_out;
    int          win;

    function automatic bit is_plain(input logic [7:0] a);
        return a inside {8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                         8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        if (a == 8'hC0) return m_en;
        if (a == 8'hD0) return m_st;
        if (is_plain(a) && m_mem.exists(int'(a))) return m_mem[int'(a)];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mem.delete();
            m_en = 0; m_st = 0; m_rd = 0; m_prev = 0; m_out = 0;
        end else begin
            rd_next = mread(bus_addr);
            hit = (irq_in ^ m_prev) & m_en[15:0];
            if (bus_we) begin
                if (bus_addr == 8'hC0)      m_en = bus_wdata & 32'h000FEEFF;
                else if (bus_addr == 8'hD0) m_st = bus_wdata & 32'h000FEEFF;
                else if (is_plain(bus_addr)) m_mem[int'(bus_addr)] = bus_wdata;
            end
            if (hit != 0) begin
                win = 0;
                for (int i = 15; i >= 0; i--) if (hit[i]) win = i;
                m_st = 32'h1 << win;
                m_out = irq_in[win];
            end
            m_prev = irq_in;
            m_rd = rd_next;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk(bus_rdata === m_rd, "rdata", bus_rdata, m_rd);
        chk(irq_out === m_out, "irq_out", {31'b0, irq_out}, {31'b0, m_out});
    end

    task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d);
        bus_addr = a; bus_we = we; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(a, 1'b0, 32'h0);
        cyc(a, 1'b0, 32'h0);
    endtask

    task automatic set_irq(input logic [15:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] offs [14] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88,
                             8'h90, 8'hE0, 8'hE4, 8'hC0, 8'hD0, 8'h20, 8'hF0};

    initial begin
        logic [31:0] lf;
        @(negedge clk); @(negedge clk); @(negedge clk);
        cur_req = "R9"; // reset state
        chk(bus_rdata === 32'h0 && irq_out === 1'b0, "reset outputs", bus_rdata, 32'h0);
        rst = 1'b0;
        rd(8'hC0); rd(8'hD0);

        cur_req = "R1";
        for (int i = 0; i < 10; i++) cyc(offs[i], 1'b1, 32'hA5C3_0F00 ^ (32'h1111_1111 * i));
        for (int i = 0; i < 10; i++) rd(offs[i]);

        cur_req = "R2"; // back-to-back write then read
        cyc(8'h60, 1'b1, 32'hDEAD_BEEF);
        cyc(8'h60, 1'b0, 0); cyc(8'h60, 1'b1, 32'h0123_4567); cyc(8'h60, 1'b0, 0); cyc(8'h60, 1'b0, 0);

        cur_req = "R3";
        cyc(8'hC0, 1'b1, 32'hFFFF_FFFF); rd(8'hC0);
        cyc(8'hD0, 1'b1, 32'hFFFF_FFFF); rd(8'hD0);

        cur_req = "R8";
        cyc(8'h20, 1'b1, 32'h5555_5555); cyc(8'h44, 1'b1, 32'h7777_7777); cyc(8'h12, 1'b1, 32'h1);
        rd(8'h20); rd(8'h44); rd(8'h12);
        for (int i = 0; i < 12; i++) rd(offs[i]);

        cur_req = "R4";
        cyc(8'hC0, 1'b1, 32'h0000_FFFF);
        set_irq(16'h0008); rd(8'hD0);
        cur_req = "R5";
        set_irq(16'h0000); rd(8'hD0);

        cur_req = "R6";
        cyc(8'hC0, 1'b1, 32'h0000_0020);
        set_irq(16'h0004); rd(8'hD0);
        cyc(8'hC0, 1'b1, 32'h0000_0024); rd(8'hD0);
        set_irq(16'h0004); rd(8'hD0);

        cur_req = "R7";
        cyc(8'hC0, 1'b1, 32'h0000_FFFF);
        set_irq(16'h0212); rd(8'hD0);
        set_irq(16'h0200); rd(8'hD0);

        cur_req = "R10";
        set_irq(16'h1300); rd(8'hD0);
        set_irq(16'h0200); rd(8'hD0);

        cur_req = "R11";
        irq_in = 16'h0280;
        cyc(8'hD0, 1'b1, 32'h0000_0001); rd(8'hD0);

        cur_req = "R2"; // mixed traffic
        lf = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] < 4) irq_in = lf[27:12];
            cyc(offs[lf[7:4] % 14], lf[9], {lf[15:0], lf[31:16]});
        end

        cur_req = "R9";
        rst = 1'b1; @(negedge clk); @(negedge clk);
        rst = 1'b0; rd(8'hC0); rd(8'h10);
        finish_run();
    end

endmodule